// File: doc/BRIEF.md
# G.711 Companding Expander for a DAC Audio Path

This block sits between the word deserialiser of a serial audio port and the DAC datapath. For every received audio word it produces one 16-bit two's-complement linear sample. When companding is selected, the eight most significant bits of the word hold a G.711 code. The block first removes the bit inversion applied on the line, then expands the code through eight piecewise-linear segments. The segment count comes from a 3-bit exponent, with a 4-bit mantissa inside each segment.

The law is chosen at run time by a 2-bit selector: plain linear, a reserved value, µ-law or A-law. A separate narrow-sample flag changes only the linear path, where it keeps just the top byte of the word. All mode inputs are taken together with the word they accompany, and one register stage sits between input and output.

Top module: `g711_expander`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted word, out_valid is 0 and out_sample is 16'h0000.
- R2: A word is accepted in every cycle where in_valid is 1. out_valid is 1 exactly one clock after each accepted word and 0 otherwise, so back-to-back words give back-to-back samples in the same order.
- R3: In cycles with no accepted word, out_sample keeps the value of the last produced sample.
- R4: With law_sel = 2'b00 and narrow_mode = 0, out_sample equals the top 16 bits of in_word (the whole word at the default width of 16).
- R5: law_sel = 2'b01 is reserved and gives exactly the same result as 2'b00.
- R6: With law_sel[1] = 0 and narrow_mode = 1, out_sample is {in_word[top 8 bits], 8'h00}.
- R7: With law_sel = 2'b10 (µ-law), let c = ~in_word[top 8 bits], exponent e = c[6:4] and mantissa m = c[3:0]. The magnitude is (((m<<3)+132)<<e)-132, and the sample is negative when c[7] = 1.
- R8: With law_sel = 2'b11 (A-law), let c = in_word[top 8 bits] ^ 8'h55, e = c[6:4] and m = c[3:0]. The magnitude is (m<<4)+8 for e = 0 and ((m<<4)+264)<<(e-1) otherwise, and the sample is positive when c[7] = 1.
- R9: In the µ-law and A-law modes, narrow_mode and the bits of in_word below the top byte have no effect on out_sample.
- R10: law_sel and narrow_mode are taken in the cycle a word is accepted. A change applies from the next accepted word onward, even when the words arrive back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received word present this cycle |
| in_word | input | WORD_W | Received audio word, companded code in its top byte |
| law_sel | input | 2 | 00 linear, 01 reserved (linear), 10 µ-law, 11 A-law |
| narrow_mode | input | 1 | Keep only the top byte in the linear modes |
| out_valid | output | 1 | Linear sample present |
| out_sample | output | 16 | Two's-complement linear sample |

## Verification
A change of law or of the narrow flag can coincide with a word being accepted, in the same cycle that the previous word's result comes out. The bench provokes this by keeping in_valid high while changing law_sel and narrow_mode on every word. It also repeats one word through all four selector values in consecutive cycles. A scoreboard records the expected sample for each word, using the settings driven with that word. Each output is then compared in order, so any result that used the old or the new setting is caught.

// File: rtl/g711_pkg.sv
package g711_pkg;
   localparam int SAMPLE_W = 16;
   localparam int CODE_W   = 8;

   typedef enum logic [1:0] {
      LAW_LINEAR = 2'b00,
      LAW_RSVD   = 2'b01,
      LAW_MU     = 2'b10,
      LAW_A      = 2'b11
   } law_e;

   typedef struct packed {
      logic       sign;
      logic [2:0] seg;
      logic [3:0] mant;
   } code_t;

   localparam logic [CODE_W-1:0] MU_LINE_MASK = 8'hFF;
   localparam logic [CODE_W-1:0] A_LINE_MASK  = 8'h55;
   localparam logic [SAMPLE_W-1:0] MU_BIAS    = 16'h0084;
   localparam logic [SAMPLE_W-1:0] A_STEP     = 16'h0108;
endpackage

// File: rtl/g711_line_undo.sv
module g711_line_undo
   import g711_pkg::*;
#(
   parameter logic [CODE_W-1:0] MASK = 8'hFF
) (
   input  logic [CODE_W-1:0] line_code,
   output code_t             code
);
   logic [CODE_W-1:0] plain;

   assign plain = line_code ^ MASK;
   assign code  = code_t'(plain);
endmodule

// File: rtl/g711_mu_dec.sv
module g711_mu_dec
   import g711_pkg::*;
(
   input  code_t               code,
   output logic [SAMPLE_W-1:0] sample
);
   logic [SAMPLE_W-1:0] biased;
   logic [SAMPLE_W-1:0] mag;

   always_comb begin
      biased = ({9'd0, code.mant, 3'b000} + MU_BIAS) << code.seg;
      mag    = biased - MU_BIAS;
      sample = code.sign ? (~mag + 16'd1) : mag;
   end
endmodule

// File: rtl/g711_a_dec.sv
module g711_a_dec
   import g711_pkg::*;
(
   input  code_t               code,
   output logic [SAMPLE_W-1:0] sample
);
   logic [SAMPLE_W-1:0] base;
   logic [SAMPLE_W-1:0] mag;
   logic [2:0]          sh;

   always_comb begin
      base = {8'd0, code.mant, 4'b0000};
      sh   = code.seg - 3'd1;
      if (code.seg == 3'd0)
         mag = base + 16'd8;
      else
         mag = (base + A_STEP) << sh;
      sample = code.sign ? mag : (~mag + 16'd1);
   end
endmodule

// File: rtl/g711_linear_pass.sv
module g711_linear_pass
   import g711_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0]   word,
   input  logic                narrow,
   output logic [SAMPLE_W-1:0] sample
);
   localparam int PAD_W = (WORD_W >= SAMPLE_W) ? 1 : SAMPLE_W - WORD_W;

   logic [SAMPLE_W-1:0] full;

   generate
      if (WORD_W >= SAMPLE_W) begin : g_trim
         assign full = word[WORD_W-1 -: SAMPLE_W];
      end else begin : g_pad
         assign full = {word, {PAD_W{1'b0}}};
      end
   endgenerate

   assign sample = narrow ? {word[WORD_W-1 -: CODE_W], 8'h00} : full;
endmodule

// File: rtl/g711_expander.sv
module g711_expander
   import g711_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic [1:0]        law_sel,
   input  logic              narrow_mode,
   output logic              out_valid,
   output logic [15:0]       out_sample
);
   initial begin
      assert (WORD_W >= CODE_W && WORD_W <= 32)
         else $error("g711_expander: WORD_W must lie in 8..32");
   end

   logic [CODE_W-1:0]   line_code;
   code_t               mu_code;
   code_t               a_code;
   logic [SAMPLE_W-1:0] mu_sample;
   logic [SAMPLE_W-1:0] a_sample;
   logic [SAMPLE_W-1:0] lin_sample;
   logic [SAMPLE_W-1:0] next_sample;
   law_e                law;

   assign line_code = in_word[WORD_W-1 -: CODE_W];
   assign law       = law_e'(law_sel);

   g711_line_undo #(.MASK(MU_LINE_MASK)) u_mu_undo (
      .line_code (line_code),
      .code      (mu_code)
   );

   g711_line_undo #(.MASK(A_LINE_MASK)) u_a_undo (
      .line_code (line_code),
      .code      (a_code)
   );

   g711_mu_dec u_mu_dec (
      .code   (mu_code),
      .sample (mu_sample)
   );

   g711_a_dec u_a_dec (
      .code   (a_code),
      .sample (a_sample)
   );

   g711_linear_pass #(.WORD_W(WORD_W)) u_lin (
      .word   (in_word),
      .narrow (narrow_mode),
      .sample (lin_sample)
   );

   always_comb begin
      unique case (law)
         LAW_MU:  next_sample = mu_sample;
         LAW_A:   next_sample = a_sample;
         default: next_sample = lin_sample;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_sample <= next_sample;
      end
   end
endmodule

// File: rtl/g711_expander_chk.sv
module g711_expander_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] in_word,
   input logic [1:0]        law_sel,
   input logic              narrow_mode,
   input logic              out_valid,
   input logic [15:0]       out_sample
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_sample == 16'h0000));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample));

   generate
      if (WORD_W >= 16) begin : g_pass_chk
         assert_linear_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !law_sel[1] && !narrow_mode)
            |=> out_sample == $past(in_word[WORD_W-1 -: 16]));
      end
   endgenerate

   assert_narrow_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !law_sel[1] && narrow_mode) |=> out_sample[7:0] == 8'h00);

   assert_mu_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && law_sel == 2'b10)
      |=> ($signed(out_sample) <= 16'sd32124 && $signed(out_sample) >= -16'sd32124));

   assert_a_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && law_sel == 2'b11)
      |=> (out_sample != 16'h0000 && $signed(out_sample) <= 16'sd32256
           && $signed(out_sample) >= -16'sd32256));
endmodule

bind g711_expander g711_expander_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/g711_expander_bench.sv
module g711_expander_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [15:0] in_word;
   logic [1:0]  law_sel;
   logic        narrow_mode;
   logic        out_valid;
   logic [15:0] out_sample;

   int total = 0;
   int bad   = 0;
   int sent  = 0;
   int seen  = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] last_exp = 16'h0000;

   always #2.5 clk = ~clk;

   g711_expander u_g711_expander (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_word     (in_word),
      .law_sel     (law_sel),
      .narrow_mode (narrow_mode),
      .out_valid   (out_valid),
      .out_sample  (out_sample)
   );

   function automatic logic [15:0] ref_mu(input logic [7:0] line);
      logic [7:0] c;
      int m, e, mag, v;
      c   = ~line;
      m   = int'(c[3:0]);
      e   = int'(c[6:4]);
      mag = 4 * (((2 * m + 33) << e) - 33);
      v   = c[7] ? -mag : mag;
      return v[15:0];
   endfunction

   function automatic logic [15:0] ref_a(input logic [7:0] line);
      logic [7:0] c;
      int m, e, mag, v;
      c   = line ^ 8'h55;
      m   = int'(c[3:0]);
      e   = int'(c[6:4]);
      mag = (e == 0) ? (2 * m + 1) * 8 : (2 * m + 33) << (e + 2);
      v   = c[7] ? mag : -mag;
      return v[15:0];
   endfunction

   function automatic logic [15:0] ref_out(input logic [15:0] w, input logic [1:0] law,
                                           input logic nm);
      case (law)
         2'b10:   return ref_mu(w[15:8]);
         2'b11:   return ref_a(w[15:8]);
         default: return nm ? {w[15:8], 8'h00} : w;
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input logic [1:0] law, input logic nm,
                       input string tag);
      @(negedge clk);
      in_valid    = 1'b1;
      in_word     = w;
      law_sel     = law;
      narrow_mode = nm;
      exp_q.push_back(ref_out(w, law, nm));
      tag_q.push_back(tag);
      sent++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid    = 1'b0;
         in_word     = 16'($urandom);
         law_sel     = 2'($urandom);
         narrow_mode = 1'($urandom);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (out_valid === 1'b1) begin
            seen++;
            if (exp_q.size() == 0) begin
               total++;
               bad++;
               $display("FAIL R2: actual=valid-without-word expected=no-valid");
            end else begin
               last_exp = exp_q.pop_front();
               check(tag_q.pop_front(), out_sample, last_exp);
            end
         end else begin
            check("R3", out_sample, last_exp);
         end
      end
   end

   task automatic run_all();
      rst_n = 1'b0; in_valid = 1'b0; in_word = '0; law_sel = 2'b00; narrow_mode = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", {15'd0, out_valid}, 16'd0);
      check("R1", out_sample, 16'h0000);
      rst_n = 1'b1;
      idle(2);
      // every µ-law code, junk in low byte and random narrow flag (R7, R9)
      for (int c = 0; c < 256; c++)
         send({c[7:0], 8'($urandom)}, 2'b10, 1'($urandom), "R7");
      idle(3);
      // every A-law code, same treatment (R8, R9)
      for (int c = 0; c < 256; c++)
         send({c[7:0], 8'($urandom)}, 2'b11, 1'($urandom), "R8");
      idle(2);
      // R9: same code, differing low bytes and narrow flag, must match
      send(16'h3A00, 2'b10, 1'b0, "R9");
      send(16'h3AFF, 2'b10, 1'b1, "R9");
      send(16'hD500, 2'b11, 1'b0, "R9");
      send(16'hD5C3, 2'b11, 1'b1, "R9");
      // linear modes with gaps (R4, R5, R6, R3)
      for (int i = 0; i < 40; i++) begin
         send(16'($urandom), 2'b00, 1'b0, "R4");
         send(16'($urandom), 2'b01, 1'b0, "R5");
         send(16'($urandom), 2'($urandom % 2), 1'b1, "R6");
         if (i % 5 == 0) idle(2);
      end
      // R10 / R2: back-to-back words, settings change on every word
      for (int i = 0; i < 64; i++)
         send(16'h9C5A, 2'(i % 4), 1'(i / 4), "R10");
      for (int i = 0; i < 60; i++)
         send(16'($urandom), 2'($urandom), 1'($urandom), "R10");
      idle(4);
      check("R2", 16'(exp_q.size()), 16'd0);
      check("R2", 16'(seen), 16'(sent));
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule